// File: doc/BRIEF.md
# Boot-Overlay System Address Decoder

This block turns the 24-bit byte address of a 68000-style processor bus into one-hot chip selects. The selects go to the working RAM, the boot ROM, a serial controller (with separate read and write selects), a peripheral interface adapter and a disk controller. The 16 MB space is cut into four 4 MB zones by the two top address bits. RAM and ROM are mirrored across their zones because only their low address bits are decoded.

At power-on an overlay state is active. In that state the ROM answers at address zero, so the processor can fetch its reset vectors, and RAM answers in the upper half of the ROM zone. Boot software pulses an overlay-clear input once the vectors are no longer needed. After that the normal map holds until the next reset. The block also outputs the RAM-relative and ROM-relative offsets that the memories use.

The selects are combinational from the address, the strobe and the registered overlay flag. The only state in the block is that one flag.

Top module: `sys_addr_decode`

## Requirements
- R1: With the overlay cleared and the strobe active, zone 0 ($000000-$3FFFFF) asserts the RAM select and zone 1 ($400000-$7FFFFF) asserts the ROM select, for reads and writes.
- R2: With the overlay active and the strobe active, $000000-$5FFFFF asserts the ROM select and $600000-$7FFFFF asserts the RAM select.
- R3: In zone 2, a read (rw=1) in $800000-$9FFFFF asserts the serial read select, and a write (rw=0) in $A00000-$BFFFFF asserts the serial write select. A write in the read half or a read in the write half asserts no select. This holds in both overlay states.
- R4: In zone 3, addresses with bit 21 clear ($C00000-$DFFFFF) assert the disk controller select, and addresses with bit 21 set ($E00000-$FFFFFF) assert the interface adapter select, in both overlay states.
- R5: While the address strobe as_n is high, every select is low, whatever the address, rw or overlay state.
- R6: At most one select is high at any time.
- R7: Reset makes the overlay active. When ovl_clr is high at a rising clock edge, the overlay is cleared from that edge on. Once cleared, it stays cleared until the next reset, and further ovl_clr pulses change nothing.
- R8: ram_off always equals address bits 16:0 (128 KB mirror) and rom_off always equals address bits 15:0 (64 KB mirror), in both overlay states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay flag |
| rst_n | input | 1 | Asynchronous active-low reset; sets the overlay |
| addr | input | 24 | Byte address from the bus |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| ovl_clr | input | 1 | Single-cycle pulse that clears the overlay |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| sel_ser_rd | output | 1 | Serial controller read select |
| sel_ser_wr | output | 1 | Serial controller write select |
| sel_dsk | output | 1 | Disk controller select |
| sel_pia | output | 1 | Peripheral interface adapter select |
| ram_off | output | 17 | RAM-relative byte offset |
| rom_off | output | 16 | ROM-relative byte offset |

## Verification
The hardest state to reach from the ports is the overlay-active decode of zones 2 and 3. The overlay exists only between reset and the first clear pulse. The vector walk therefore applies every overlay-active row before it issues the single clear, and afterwards it covers the whole map again with the normal decode. A second reset, followed by a repeated clear pulse, checks that the flag comes back and that a second pulse has no extra effect.

// File: rtl/sys_addr_decode_pkg.sv
package sys_addr_decode_pkg;

    typedef enum logic [1:0] {
        ZONE_LOW  = 2'd0,
        ZONE_ROM  = 2'd1,
        ZONE_SER  = 2'd2,
        ZONE_IO   = 2'd3
    } zone_e;

    typedef struct packed {
        logic ram;
        logic rom;
        logic ser_rd;
        logic ser_wr;
        logic dsk;
        logic pia;
    } sel_t;

    typedef struct packed {
        logic overlay;
    } ovl_state_t;

endpackage

// File: rtl/sys_ovl_flag.sv
module sys_ovl_flag
    import sys_addr_decode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovl_clr,
    output logic overlay
);

    ovl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovl_clr) begin
            st_d.overlay = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.overlay <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign overlay = st_q.overlay;

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_clr |=> !overlay); // R7
    AST_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay |=> !overlay); // R7

endmodule

// File: rtl/sys_zone_decode.sv
module sys_zone_decode
    import sys_addr_decode_pkg::*;
(
    input  logic [2:0] addr_hi,
    input  logic       strobe,
    input  logic       rw,
    input  logic       overlay,
    output sel_t       sel
);

    zone_e zone;
    logic  half;

    assign zone = zone_e'(addr_hi[2:1]);
    assign half = addr_hi[0];

    always_comb begin
        sel = '0;
        if (strobe) begin
            unique case (zone)
                ZONE_LOW: begin
                    if (overlay) sel.rom = 1'b1;
                    else         sel.ram = 1'b1;
                end
                ZONE_ROM: begin
                    if (overlay && half) sel.ram = 1'b1;
                    else                 sel.rom = 1'b1;
                end
                ZONE_SER: begin
                    if (!half && rw)      sel.ser_rd = 1'b1;
                    else if (half && !rw) sel.ser_wr = 1'b1;
                end
                ZONE_IO: begin
                    if (half) sel.pia = 1'b1;
                    else      sel.dsk = 1'b1;
                end
                default: sel = '0;
            endcase
        end
    end

endmodule

// File: rtl/sys_addr_decode.sv
module sys_addr_decode
    import sys_addr_decode_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int RAM_AW = 17,
    parameter int ROM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              rw,
    input  logic              ovl_clr,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              sel_ser_rd,
    output logic              sel_ser_wr,
    output logic              sel_dsk,
    output logic              sel_pia,
    output logic [RAM_AW-1:0] ram_off,
    output logic [ROM_AW-1:0] rom_off
);

    localparam int HALF_BIT = ADDR_W - 3;

    logic overlay;
    sel_t sel;
    logic unused_mid;

    sys_ovl_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovl_clr (ovl_clr),
        .overlay (overlay)
    );

    sys_zone_decode u_zone (
        .addr_hi (addr[ADDR_W-1:HALF_BIT]),
        .strobe  (!as_n),
        .rw      (rw),
        .overlay (overlay),
        .sel     (sel)
    );

    assign sel_ram    = sel.ram;
    assign sel_rom    = sel.rom;
    assign sel_ser_rd = sel.ser_rd;
    assign sel_ser_wr = sel.ser_wr;
    assign sel_dsk    = sel.dsk;
    assign sel_pia    = sel.pia;

    assign ram_off = addr[RAM_AW-1:0];
    assign rom_off = addr[ROM_AW-1:0];

    assign unused_mid = ^addr[HALF_BIT-1:RAM_AW];

    AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_rom, sel_ser_rd, sel_ser_wr, sel_dsk, sel_pia})); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> !(sel_ram || sel_rom || sel_ser_rd || sel_ser_wr || sel_dsk || sel_pia)); // R5
    AST_SER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ser_rd |-> rw) and (sel_ser_wr |-> !rw)); // R3
    AST_OVL_LOW_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && overlay && addr[ADDR_W-1:ADDR_W-2] == 2'd0) |-> sel_rom); // R2

endmodule

// File: tb/tb_sys_addr_decode.sv
`timescale 1ns/1ps
module tb_sys_addr_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic        ovl_clr = 1'b0;
    logic        sel_ram, sel_rom, sel_ser_rd, sel_ser_wr, sel_dsk, sel_pia;
    logic [16:0] ram_off;
    logic [15:0] rom_off;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sys_addr_decode dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .rw(rw), .ovl_clr(ovl_clr),
        .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_ser_rd(sel_ser_rd),
        .sel_ser_wr(sel_ser_wr), .sel_dsk(sel_dsk), .sel_pia(sel_pia),
        .ram_off(ram_off), .rom_off(rom_off)
    );

    // select order: {ram, rom, ser_rd, ser_wr, dsk, pia}
    localparam logic [5:0] S_RAM = 6'b100000, S_ROM = 6'b010000, S_RD = 6'b001000,
                           S_WR = 6'b000100, S_DSK = 6'b000010, S_PIA = 6'b000001,
                           S_NONE = 6'b000000;
    // vector: {addr[23:0], rw, overlay, expected selects}
    localparam int NV = 28;
    localparam logic [31:0] VEC [NV] = '{
        {24'h000000, 1'b1, 1'b1, S_ROM},  // R2
        {24'h3FFFFF, 1'b0, 1'b1, S_ROM},  // R2
        {24'h400000, 1'b1, 1'b1, S_ROM},  // R2
        {24'h5FFFFF, 1'b1, 1'b1, S_ROM},  // R2
        {24'h600000, 1'b1, 1'b1, S_RAM},  // R2
        {24'h7FFFFF, 1'b0, 1'b1, S_RAM},  // R2
        {24'h800000, 1'b1, 1'b1, S_RD},   // R3
        {24'hBFFFF9, 1'b0, 1'b1, S_WR},   // R3
        {24'hC00000, 1'b1, 1'b1, S_DSK},  // R4
        {24'hFFFFFF, 1'b1, 1'b1, S_PIA},  // R4
        {24'h000000, 1'b1, 1'b0, S_RAM},  // R1
        {24'h3FFFFF, 1'b0, 1'b0, S_RAM},  // R1
        {24'h400000, 1'b1, 1'b0, S_ROM},  // R1
        {24'h600000, 1'b1, 1'b0, S_ROM},  // R1
        {24'h7FFFFF, 1'b0, 1'b0, S_ROM},  // R1
        {24'h800000, 1'b1, 1'b0, S_RD},   // R3
        {24'h9FFFF8, 1'b1, 1'b0, S_RD},   // R3
        {24'h9FFFFF, 1'b0, 1'b0, S_NONE}, // R3
        {24'hA00000, 1'b0, 1'b0, S_WR},   // R3
        {24'hBFFFF9, 1'b0, 1'b0, S_WR},   // R3
        {24'hBFFFFF, 1'b1, 1'b0, S_NONE}, // R3
        {24'hC00000, 1'b1, 1'b0, S_DSK},  // R4
        {24'hDFE1FF, 1'b0, 1'b0, S_DSK},  // R4
        {24'hDFFFFF, 1'b1, 1'b0, S_DSK},  // R4
        {24'hE00000, 1'b0, 1'b0, S_PIA},  // R4
        {24'hEFE1FE, 1'b1, 1'b0, S_PIA},  // R4
        {24'hFFFFFF, 1'b1, 1'b0, S_PIA},  // R4
        {24'h3ABCDE, 1'b1, 1'b0, S_RAM}   // R1
    };

    function automatic logic [5:0] sels();
        return {sel_ram, sel_rom, sel_ser_rd, sel_ser_wr, sel_dsk, sel_pia};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    task automatic apply(input logic [23:0] a, input logic r, input logic strobe_n);
        @(negedge clk);
        addr = a; rw = r; as_n = strobe_n;
        #1;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        ovl_clr = 1'b1;
        @(negedge clk);
        ovl_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        as_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic ovl_now;
        do_reset();
        ovl_now = 1'b1;

        // reset state: idle, then overlay active at zero
        apply(24'h000000, 1'b1, 1'b1);
        check("R5", {26'd0, sels()}, {26'd0, S_NONE});
        apply(24'h000000, 1'b1, 1'b0);
        check("R7", {26'd0, sels()}, {26'd0, S_ROM});

        for (int i = 0; i < NV; i++) begin
            logic [23:0] a;
            a = VEC[i][31:8];
            if (ovl_now && !VEC[i][6]) begin
                pulse_clear();
                ovl_now = 1'b0;
            end
            apply(a, VEC[i][7], 1'b0);
            check(VEC[i][6] ? "R2/R3/R4 overlay" : "R1/R3/R4 normal",
                  {26'd0, sels()}, {26'd0, VEC[i][5:0]});
            check("R8 ram_off", {15'd0, ram_off}, {15'd0, a[16:0]});
            check("R8 rom_off", {16'd0, rom_off}, {16'd0, a[15:0]});
            check("R6", $countones(sels()), (VEC[i][5:0] == 6'd0) ? 0 : 1);
        end

        // R5: strobe inactive across several zones
        for (int z = 0; z < 4; z++) begin
            apply({z[1:0], 22'h2AAAAA}, z[0], 1'b1);
            check("R5", {26'd0, sels()}, {26'd0, S_NONE});
        end

        // R7: second clear pulse while cleared has no effect
        pulse_clear();
        apply(24'h000010, 1'b1, 1'b0);
        check("R7 repeat clear", {26'd0, sels()}, {26'd0, S_RAM});

        // R7: reset brings overlay back; clear takes effect the edge it is seen
        do_reset();
        apply(24'h600004, 1'b1, 1'b0);
        check("R7 overlay after reset", {26'd0, sels()}, {26'd0, S_RAM});
        @(negedge clk);
        addr = 24'h000004;
        ovl_clr = 1'b1;
        #1;
        check("R7 before edge", {26'd0, sels()}, {26'd0, S_ROM});
        @(negedge clk);
        ovl_clr = 1'b0;
        #1;
        check("R7 after edge", {26'd0, sels()}, {26'd0, S_RAM});
        apply(24'h600004, 1'b0, 1'b0);
        check("R7 normal map", {26'd0, sels()}, {26'd0, S_ROM});
        apply(24'h600004, 1'b0, 1'b1);
        check("R5", {26'd0, sels()}, {26'd0, S_NONE});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule